// File: doc/BRIEF.md
# Interrupt Request Capture Cells

This block holds the pending-request register of a programmable interrupt controller. Each of its request lines feeds one cell. A cell first passes the raw line through a synchronizer. It then turns the synchronized level into a stored request bit. The downstream priority resolver reads the resulting vector directly. Masking, in-service tracking and bus cycles belong to other blocks. Nothing downstream writes back into this register except the per-line acknowledge clear.

The trigger mode is shared by all lines. It is loaded from the trigger-mode field of the first initialization word, and the field is presented on its own pin together with the strobe that marks that word. In edge mode, a line requests once per low-to-high transition. Its cell must see the line low again before it can request a second time. In level mode, the stored bit simply follows the synchronized line.

Three other controls shape the cell. The initialization strobe clears everything. The freeze input holds the register steady while an acknowledge or poll sequence is running. The acknowledge logic clears only the bit it has just granted.

Top module: `irq_capture_cells`

## Requirements
- R1: After reset, every bit of `req_vec` is 0, the trigger mode is edge, and no line is armed.
- R2: A cycle with `icw_wr` high clears every bit of `req_vec` at the next edge and disarms every line. The same edge loads the trigger mode from `init_trig_level`, where 1 selects level mode and 0 selects edge mode.
- R3: While `freeze` is high, `icw_wr` is low and `ack_clr` is zero, `req_vec` keeps its value, whatever the request lines do.
- R4: In edge mode, consider an armed line whose input goes from low to high. The line is armed once it has been seen low. Its request bit rises SYNC_STAGES+1 clock edges after the input change. The bit then stays set until it is cleared.
- R5: In edge mode, a line that stays high after its edge has been captured produces no new request after an acknowledge clear. It requests again only after its input has been seen low and then high.
- R6: In level mode, when not frozen, each request bit equals the line's input delayed by SYNC_STAGES+1 edges. The bit drops when the input goes low.
- R7: A 1 in bit i of `ack_clr` clears bit i of `req_vec` at the next edge, even while frozen, and leaves the other bits untouched.
- R8: In edge mode, an edge that arrives while frozen is not lost. If the line is still high when freeze drops, the request is captured at the first unfrozen edge.
- R9: `icw_wr` takes priority over freeze, acknowledge clear and new captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| icw_wr | input | 1 | High for one cycle while the first initialization word is written |
| init_trig_level | input | 1 | Trigger-mode field of that word (1 = level, 0 = edge) |
| freeze | input | 1 | Holds the request register during acknowledge and poll sequences |
| irq_in | input | LINES | Raw asynchronous request lines |
| ack_clr | input | LINES | Per-line clear from the acknowledge logic |
| req_vec | output | LINES | Stored request vector for priority resolution |

## Verification
The bench drives a line that stays high across an acknowledge clear. A design that re-arms on level rather than on a seen-low would raise the request again at once. It drives edges during freeze. A design that consumes the edge while frozen would lose that request after release. It also applies acknowledge and initialization during freeze, which catches a wrong priority order among hold, clear and master clear. Last, it checks that capture happens exactly SYNC_STAGES+1 edges after the input changes, so a missing or extra synchronizer stage shows up as an off-by-one cycle.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  // Edge capture: armed line seen high, not held, not being cleared.
  function automatic logic cell_capture(trig_mode_e mode, logic s, logic armed,
                                        logic frz, logic clr);
    return (mode == TRIG_EDGE) && s && armed && !frz && !clr;
  endfunction

  // Next request bit: clear wins over hold, hold wins over capture.
  function automatic logic cell_next_req(trig_mode_e mode, logic s, logic req,
                                         logic frz, logic clr, logic cap);
    logic nxt;
    if (clr)                     nxt = 1'b0;
    else if (frz)                nxt = req;
    else if (mode == TRIG_LEVEL) nxt = s;
    else                         nxt = req | cap;
    return nxt;
  endfunction

  // Arming: a low level arms, a capture disarms, otherwise keep.
  function automatic logic cell_next_arm(logic s, logic armed, logic cap);
    logic nxt;
    if (!s)       nxt = 1'b1;
    else if (cap) nxt = 1'b0;
    else          nxt = armed;
    return nxt;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[k] <= '0;
        else        stg[k] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[k] <= '0;
        else        stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg
  import irq_cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       icw_wr,
  input  logic       trig_level,
  output trig_mode_e mode
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      mode <= TRIG_EDGE;
    else if (icw_wr) mode <= trig_level ? TRIG_LEVEL : TRIG_EDGE;
endmodule

// File: rtl/irq_cell.sv
module irq_cell
  import irq_cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode,
  input  logic       init_clr,
  input  logic       frz,
  input  logic       clr,
  input  logic       s,
  output logic       req,
  output logic       armed,
  output logic       cap
);
  logic req_q, arm_q;

  assign cap = cell_capture(mode, s, arm_q, frz, clr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (init_clr) begin
      req_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      req_q <= cell_next_req(mode, s, req_q, frz, clr, cap);
      arm_q <= cell_next_arm(s, arm_q, cap);
    end

  assign req   = req_q;
  assign armed = arm_q;
endmodule

// File: rtl/irq_capture_cells.sv
module irq_capture_cells
  import irq_cap_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             icw_wr,
  input  logic             init_trig_level,
  input  logic             freeze,
  input  logic [LINES-1:0] irq_in,
  input  logic [LINES-1:0] ack_clr,
  output logic [LINES-1:0] req_vec
);
  // Named internal events, brought out for the bound checker.
  trig_mode_e       trig_mode;
  logic [LINES-1:0] sync_s;
  logic [LINES-1:0] armed;
  logic [LINES-1:0] cap_evt;

  irq_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .icw_wr    (icw_wr),
    .trig_level(init_trig_level),
    .mode      (trig_mode)
  );

  irq_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (irq_in),
    .q    (sync_s)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_cell
    irq_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (trig_mode),
      .init_clr(icw_wr),
      .frz     (freeze),
      .clr     (ack_clr[i]),
      .s       (sync_s[i]),
      .req     (req_vec[i]),
      .armed   (armed[i]),
      .cap     (cap_evt[i])
    );
  end
endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk #(
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             icw_wr,
  input logic             freeze,
  input logic             level_mode,
  input logic [LINES-1:0] ack_clr,
  input logic [LINES-1:0] sync_s,
  input logic [LINES-1:0] armed,
  input logic [LINES-1:0] cap_evt,
  input logic [LINES-1:0] req_vec
);
  p_init_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    icw_wr |=> req_vec == '0);

  p_freeze_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!icw_wr && freeze && ack_clr == '0) |=> req_vec == $past(req_vec));

  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!icw_wr && ack_clr != '0) |=> (req_vec & $past(ack_clr)) == '0);

  p_edge_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!icw_wr && !level_mode) |=>
      (req_vec & ~$past(req_vec) & ~$past(sync_s & armed)) == '0);

  p_cap_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!icw_wr && cap_evt != '0) |=> (armed & $past(cap_evt)) == '0);

  p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!icw_wr && level_mode && !freeze) |=>
      req_vec == ($past(sync_s) & ~$past(ack_clr)));
endmodule

bind irq_capture_cells irq_capture_chk #(.LINES(LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .icw_wr    (icw_wr),
  .freeze    (freeze),
  .level_mode(trig_mode == irq_cap_pkg::TRIG_LEVEL),
  .ack_clr   (ack_clr),
  .sync_s    (sync_s),
  .armed     (armed),
  .cap_evt   (cap_evt),
  .req_vec   (req_vec)
);

// File: tb/test_irq_capture_cells.sv
`timescale 1ns/1ps
module test_irq_capture_cells;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         icw_wr = 1'b0;
  logic         init_trig_level = 1'b0;
  logic         freeze = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic [N-1:0] ack_clr = '0;
  logic [N-1:0] req_vec;

  int total = 0;
  int bad   = 0;
  string cur_tag = "R1";

  // Bench reference state.
  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_arm = '0, m_req = '0;
  logic         m_level = 1'b0;

  always #2 clk = ~clk;

  irq_capture_cells i_irq_capture_cells (
    .clk(clk), .rst_n(rst_n), .icw_wr(icw_wr),
    .init_trig_level(init_trig_level), .freeze(freeze),
    .irq_in(irq_in), .ack_clr(ack_clr), .req_vec(req_vec)
  );

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: req_vec=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference: what one clock edge does, restated from the requirements.
  task automatic model_edge();
    logic [N-1:0] nreq, narm;
    for (int i = 0; i < N; i++) begin
      logic take;
      take = !m_level && m_s2[i] && m_arm[i] && !freeze && !ack_clr[i];
      if (ack_clr[i])   nreq[i] = 1'b0;
      else if (freeze)  nreq[i] = m_req[i];
      else if (m_level) nreq[i] = m_s2[i];
      else              nreq[i] = m_req[i] | take;
      narm[i] = !m_s2[i] ? 1'b1 : (take ? 1'b0 : m_arm[i]);
    end
    if (icw_wr) begin
      nreq = '0; narm = '0; m_level = init_trig_level;
    end
    m_s2 = m_s1; m_s1 = irq_in; m_req = nreq; m_arm = narm;
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      model_edge();
      @(posedge clk);
      @(negedge clk);
      chk(cur_tag, req_vec, m_req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", req_vec, '0);
    rst_n = 1'b1;
    cur_tag = "R1"; tick(2);
    chk("R1", req_vec, 8'h00);

    // R2: select edge mode
    cur_tag = "R2"; icw_wr = 1; init_trig_level = 0; tick(); icw_wr = 0;
    chk("R2", req_vec, 8'h00);

    // R4: rising edge appears after three edges, not before
    cur_tag = "R4"; irq_in = 8'h01; tick(2);
    chk("R4", req_vec, 8'h00);
    tick();
    chk("R4", req_vec, 8'h01);
    tick(5);
    chk("R4", req_vec, 8'h01);

    // R7 then R5: acknowledge while line stays high
    cur_tag = "R7"; ack_clr = 8'h01; tick(); ack_clr = 0;
    chk("R7", req_vec, 8'h00);
    cur_tag = "R5"; tick(10);
    chk("R5", req_vec, 8'h00);
    irq_in = 8'h00; tick(3); irq_in = 8'h01; tick(3);
    chk("R5", req_vec, 8'h01);

    // R8: edge during freeze captured on release
    cur_tag = "R3"; freeze = 1; irq_in = 8'h03; tick(6);
    chk("R3", req_vec, 8'h01);
    cur_tag = "R8"; freeze = 0; tick();
    chk("R8", req_vec, 8'h03);

    // R7: clear wins over freeze, other bit untouched
    cur_tag = "R7"; freeze = 1; ack_clr = 8'h02; tick(); ack_clr = 0;
    chk("R7", req_vec, 8'h01);
    tick(2);
    chk("R3", req_vec, 8'h01);

    // R9: master clear wins over freeze, selects level mode
    cur_tag = "R9"; icw_wr = 1; init_trig_level = 1; tick(); icw_wr = 0;
    chk("R9", req_vec, 8'h00);
    freeze = 0;

    // R6: level mode follows input
    cur_tag = "R6"; irq_in = 8'h3C; tick(3);
    chk("R6", req_vec, 8'h3C);
    irq_in = 8'h0C; tick(2);
    chk("R6", req_vec, 8'h3C);
    tick();
    chk("R6", req_vec, 8'h0C);
    ack_clr = 8'h04; tick(); ack_clr = 0;
    chk("R7", req_vec, 8'h08);
    tick();
    chk("R6", req_vec, 8'h0C);

    // Random phase, both modes
    for (int c = 0; c < 4000; c++) begin
      cur_tag = m_level ? "R6" : "R4";
      for (int i = 0; i < N; i++)
        if ($urandom_range(7) == 0) irq_in[i] = ~irq_in[i];
      freeze  = ($urandom_range(9) == 0);
      ack_clr = ($urandom_range(4) == 0) ? (m_req & (~m_req + 1'b1)) : '0;
      icw_wr  = ($urandom_range(99) == 0);
      init_trig_level = $urandom_range(1);
      if (icw_wr) cur_tag = "R2";
      tick();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule